// File: doc/BRIEF.md
# Execute Stage with Branch Resolution

This block is the execute step of a five-step, 32-bit, word-addressed processor pipeline with sixteen registers and 4-bit opcodes. Each cycle it takes one instruction slot: the opcode, two already-forwarded source values, a 32-bit immediate that has already been sign-extended from a 20-bit field, and the incremented PC (the address of the instruction plus one). From these it computes the arithmetic or NAND result, the data memory address for loads and stores, the link value for a jump-and-link, and the PC-relative address for load-effective-address.

In the same cycle it resolves every control transfer: the unconditional branch, the two-register signed compare branches and the register-indirect jump. It raises a redirect flag with a target PC only when the resolved next PC differs from the incremented PC, so a not-taken branch, or a taken one whose offset is zero, costs no flush. The redirect is combinational so fetch can act on it at once. The result, the store data, the destination register number and three control flags are captured in a register that feeds the memory step.

Decode upstream places values by role: the first source value is SR1 for ADD, NAND, ADDI and the compare branches, the base register for LW and SW, and the target register for JALR. The second source value is SR2 for ADD, NAND and the compare branches, and the register being stored for SW.

Top module: `exec_stage`

## Requirements
- R1: Opcode 0000 (ADD) yields first+second, 0001 (NAND) yields ~(first & second), 0010 (ADDI) yields first+immediate, all modulo 2^32, with the register-write flag set.
- R2: Opcode 0011 (LW) and 0100 (SW) yield first+immediate with bits 31:16 cleared as the result; LW sets the memory-read and register-write flags, SW sets only the memory-write flag; the store-data output always carries the second source value.
- R3: Opcode 0101 (BR) resolves its next PC to incremented PC + immediate, whatever the source values.
- R4: Opcode 1000 (BLT) resolves to incremented PC + immediate when the first source value is less than the second, and 1001 (BGT) when it is greater, both as two's-complement signed numbers; otherwise the next PC is the incremented PC.
- R5: Opcode 0110 (JALR) yields the incremented PC as result with the register-write flag set, and resolves its next PC to the first source value.
- R6: Opcode 1010 (LEA) yields incremented PC + immediate with the register-write flag set and no redirect.
- R7: The redirect output is high, with the target on the redirect PC output, exactly when the slot is valid and its resolved next PC differs from the incremented PC, in the same cycle as the inputs.
- R8: Opcode 0111 (HALT) and the unused codes 1011 to 1111 set no flag, give result 0 and never redirect; the compare branches and BR set no flag either.
- R9: When the valid input is low, no flag is set in the register and no redirect is raised.
- R10: While reset is asserted the memory-step register holds all zeros; the destination number and store data pass through one cycle after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Slot holds a real instruction |
| opcode | input | 4 | Instruction opcode |
| src1 | input | 32 | First source value (SR1, base or jump target) |
| src2 | input | 32 | Second source value (SR2 or store value) |
| imm | input | 32 | Sign-extended 20-bit immediate or offset |
| pc_inc | input | 32 | Address of the instruction plus one |
| dst | input | 4 | Destination register number |
| redirect | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | 32 | Resolved next PC |
| mem_reg_we | output | 1 | Registered: instruction writes a register |
| mem_rd | output | 1 | Registered: instruction reads data memory |
| mem_wr | output | 1 | Registered: instruction writes data memory |
| mem_dst | output | 4 | Registered destination register number |
| mem_result | output | 32 | Registered result or memory address |
| mem_sdata | output | 32 | Registered store data |

## Verification
On every cycle the assertions check that read and write flags never coincide and that a load always writes a register, that any memory address has its upper half clear, that an idle slot neither redirects nor sets flags, that a redirect never names the incremented PC, that a nonzero unconditional branch always redirects, and that an ADD result appears one cycle later. The signed ordering of the compare branches, the exact targets of each transfer, and the results of NAND, ADDI, LEA and the jump-and-link link value are shown only by the bench's sweep over every opcode against corner operand values such as the most negative and most positive numbers.

// File: rtl/exec_stage.sv
module exec_stage #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int RN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    opcode,
  input  logic [DW-1:0] src1,
  input  logic [DW-1:0] src2,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] pc_inc,
  input  logic [RN-1:0] dst,
  output logic          redirect,
  output logic [DW-1:0] redirect_pc,
  output logic          mem_reg_we,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [RN-1:0] mem_dst,
  output logic [DW-1:0] mem_result,
  output logic [DW-1:0] mem_sdata
);

  localparam logic [3:0] K_ADD  = 4'b0000;
  localparam logic [3:0] K_NAND = 4'b0001;
  localparam logic [3:0] K_ADDI = 4'b0010;
  localparam logic [3:0] K_LOAD = 4'b0011;
  localparam logic [3:0] K_STOR = 4'b0100;
  localparam logic [3:0] K_JUMP = 4'b0101;
  localparam logic [3:0] K_LINK = 4'b0110;
  localparam logic [3:0] K_BLT  = 4'b1000;
  localparam logic [3:0] K_BGT  = 4'b1001;
  localparam logic [3:0] K_LEA  = 4'b1010;
  localparam int HI = DW - AW;

  logic [DW-1:0] base_sum, rel_pc, res, nxt;
  logic          less, more, we, rd, wr;

  assign base_sum = src1 + imm;
  assign rel_pc   = pc_inc + imm;
  assign less     = $signed(src1) < $signed(src2);
  assign more     = $signed(src1) > $signed(src2);

  always_comb begin
    res = '0;
    nxt = pc_inc;
    we  = 1'b0;
    rd  = 1'b0;
    wr  = 1'b0;
    case (opcode)
      K_ADD:  begin res = src1 + src2;     we = 1'b1; end
      K_NAND: begin res = ~(src1 & src2);  we = 1'b1; end
      K_ADDI: begin res = base_sum;        we = 1'b1; end
      K_LOAD: begin res = {{HI{1'b0}}, base_sum[AW-1:0]}; we = 1'b1; rd = 1'b1; end
      K_STOR: begin res = {{HI{1'b0}}, base_sum[AW-1:0]}; wr = 1'b1; end
      K_JUMP: nxt = rel_pc;
      K_LINK: begin res = pc_inc; nxt = src1; we = 1'b1; end
      K_BLT:  if (less) nxt = rel_pc;
      K_BGT:  if (more) nxt = rel_pc;
      K_LEA:  begin res = rel_pc; we = 1'b1; end
      default: ;
    endcase
  end

  assign redirect    = in_valid && (nxt != pc_inc);
  assign redirect_pc = nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_reg_we <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_dst    <= '0;
      mem_result <= '0;
      mem_sdata  <= '0;
    end else begin
      mem_reg_we <= in_valid && we;
      mem_rd     <= in_valid && rd;
      mem_wr     <= in_valid && wr;
      mem_dst    <= dst;
      mem_result <= res;
      mem_sdata  <= src2;
    end
  end

endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int RN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    opcode,
  input logic [DW-1:0] src1,
  input logic [DW-1:0] src2,
  input logic [DW-1:0] imm,
  input logic [DW-1:0] pc_inc,
  input logic [RN-1:0] dst,
  input logic          redirect,
  input logic [DW-1:0] redirect_pc,
  input logic          mem_reg_we,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [RN-1:0] mem_dst,
  input logic [DW-1:0] mem_result,
  input logic [DW-1:0] mem_sdata
);

  a_r2_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r2_load_writes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_reg_we);

  a_r2_addr_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_result[DW-1:AW] == '0));

  a_r9_idle_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !redirect);

  a_r9_idle_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!mem_reg_we && !mem_rd && !mem_wr));

  a_r7_no_self_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (redirect_pc != pc_inc));

  a_r3_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'b0101 && imm != '0) |-> redirect);

  a_r1_add_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'b0000) |=> (mem_result == $past(src1 + src2)));

endmodule

bind exec_stage exec_stage_chk #(.DW(DW), .AW(AW), .RN(RN)) u_chk (.*);

// File: tb/test_exec_stage.sv
module test_exec_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] src1 = '0, src2 = '0, imm = '0, pc_inc = '0;
  logic [3:0]  dst = '0;
  logic        redirect, mem_reg_we, mem_rd, mem_wr;
  logic [31:0] redirect_pc, mem_result, mem_sdata;
  logic [3:0]  mem_dst;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_stage i_exec_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src1(src1), .src2(src2), .imm(imm), .pc_inc(pc_inc), .dst(dst),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .mem_reg_we(mem_reg_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_dst(mem_dst), .mem_result(mem_result), .mem_sdata(mem_sdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op=%0h a=%h b=%h imm=%h: actual=%h expected=%h",
               tag, opcode, src1, src2, imm, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_slot(input logic v, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] im,
                          input logic [31:0] pc, input logic [3:0] d);
    logic [31:0] e_res, e_nxt, e_addr;
    logic e_we, e_rd, e_wr, e_redir;
    string tg;
    in_valid = v; opcode = op; src1 = a; src2 = b; imm = im; pc_inc = pc; dst = d;
    e_res = '0; e_nxt = pc; e_we = 0; e_rd = 0; e_wr = 0;
    e_addr = (a + im) & 32'h0000_FFFF;
    tg = "R8";
    case (op)
      4'd0:  begin e_res = a + b;     e_we = 1; tg = "R1"; end
      4'd1:  begin e_res = ~(a & b);  e_we = 1; tg = "R1"; end
      4'd2:  begin e_res = a + im;    e_we = 1; tg = "R1"; end
      4'd3:  begin e_res = e_addr; e_we = 1; e_rd = 1; tg = "R2"; end
      4'd4:  begin e_res = e_addr; e_wr = 1; tg = "R2"; end
      4'd5:  begin e_nxt = pc + im; tg = "R3"; end
      4'd6:  begin e_res = pc; e_nxt = a; e_we = 1; tg = "R5"; end
      4'd8:  begin if ($signed(a) < $signed(b)) e_nxt = pc + im; tg = "R4"; end
      4'd9:  begin if ($signed(a) > $signed(b)) e_nxt = pc + im; tg = "R4"; end
      4'd10: begin e_res = pc + im; e_we = 1; tg = "R6"; end
      default: ;
    endcase
    if (!v) tg = "R9";
    e_redir = v && (e_nxt != pc);
    #1;
    check({tg, "/R7 redirect"}, {31'b0, redirect}, {31'b0, e_redir});
    if (e_redir) check({tg, "/R7 target"}, redirect_pc, e_nxt);
    @(posedge clk); #1;
    check({tg, " reg_we"}, {31'b0, mem_reg_we}, {31'b0, v && e_we});
    check({tg, " mem_rd"}, {31'b0, mem_rd}, {31'b0, v && e_rd});
    check({tg, " mem_wr"}, {31'b0, mem_wr}, {31'b0, v && e_wr});
    if (v) check({tg, " result"}, mem_result, e_res);
    check("R10 dst pass", {28'b0, mem_dst}, {28'b0, d});
    check("R2 store data", mem_sdata, b);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] vals [6];
    logic [31:0] imms [3];
    vals = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd5, 32'h7FFF_FFFF, 32'h8000_0000};
    imms = '{32'd0, 32'd3, 32'hFFFF_FFFE};
    in_valid = 1'b1; opcode = 4'd0; src1 = 32'd7; src2 = 32'd9; dst = 4'd3;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset we", {31'b0, mem_reg_we}, 32'd0);
    check("R10 reset rd/wr", {30'b0, mem_rd, mem_wr}, 32'd0);
    check("R10 reset dst", {28'b0, mem_dst}, 32'd0);
    check("R10 reset result", mem_result, 32'd0);
    check("R10 reset sdata", mem_sdata, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 3; k++)
            run_slot(1'b1, op[3:0], vals[i], vals[j], imms[k],
                     32'h0000_0100 + 32'(i * 8 + k), 4'(op + i + j));
    // large base: address truncation for R2
    run_slot(1'b1, 4'd3, 32'h1234_FFFF, 32'd0, 32'd2, 32'd40, 4'd6);
    run_slot(1'b1, 4'd4, 32'hABCD_0010, 32'hDEAD_BEEF, 32'hFFFF_FFF0, 32'd41, 4'd2);
    // JALR to its own incremented PC: no redirect (R5, R7)
    run_slot(1'b1, 4'd6, 32'd77, 32'd0, 32'd0, 32'd77, 4'd15);
    for (int op = 0; op < 16; op++)
      run_slot(1'b0, op[3:0], 32'd3, 32'd9, 32'd4, 32'd20, 4'd1);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

endmodule